// File: doc/BRIEF.md
# Channel Acquisition Sequencer

This block manages a bank of 14-bit hold codes. There is one code per output channel, plus one extra code for a shared offset channel. A command on the parallel port names a target channel. The block then runs a successive-approximation search against an external comparator: it presents a trial code, and the comparator reports whether the input level is at or above that trial. The search settles on the code that matches the input and writes it into the target register. After that, the code stays as it is until the same channel is named again.

While a search runs, busy is held low, and the target channel's output-source select is raised. The raised select tells the analog stage to pass the input straight through instead of using the held code. A command can be deferred by holding the track input low. The channel then passes the input through, but the search waits for a rising edge on track. A calibrate command searches once with a longer step time and writes the result into every regular channel. A readback port returns any stored code. If a readback is requested during a search, it is kept and served once the search ends.

Top module: `acq_seq`

## Requirements
- R1: After reset every hold register (channels 0..N_CH-1 and offset index N_CH) reads back zero, busy_no is high, pass_o is all zero and trial_code_o is zero.
- R2: A command is taken on a rising edge of wr_ni seen at a clock edge while cs_ni is low; a wr_ni rising edge with cs_ni high has no effect.
- R3: With track_i high when a command is taken, busy_no is low from the next clock and stays low for exactly 14*STEP_CLKS cycles.
- R4: With track_i low when a command is taken, busy_no stays high and the target's pass_o bit is set; the search starts on the clock after track_i rises and stores the input level present then.
- R5: The search tests bits MSB first; the first trial_code_o of a search is 14'h2000, and the stored code is the largest code for which cmp_i (high when trial <= input) was high, covering codes 0 and 14'h3FFF.
- R6: pass_o bit i is high exactly while channel i is waiting or being acquired; it falls on the same clock busy_no rises, when the new code is already stored.
- R7: offs_sel_i high targets the offset register (index N_CH) and addr_i is ignored.
- R8: cal_i high loads all N_CH regular registers with one search, sets all their pass_o bits, leaves the offset register unchanged, and holds busy_no low for 14*CAL_STEP_CLKS cycles.
- R9: A register not targeted by a completing search keeps its code.
- R10: Commands arriving while busy_no is low are ignored.
- R11: A readback request (rd_req_i, rd_sel_i: 0..N_CH-1 channels, N_CH offset) made while busy_no is high gives rd_valid_o for one cycle on the next clock, with the stored code on rd_data_o.
- R12: A readback requested while busy_no is low is held and served one cycle after busy_no returns high, returning the code written by that search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Active-low chip select for commands |
| wr_ni | input | 1 | Active-low write strobe; command taken on its rising edge |
| addr_i | input | 5 | Channel address |
| offs_sel_i | input | 1 | Target the offset channel |
| cal_i | input | 1 | Calibrate: load all regular channels |
| track_i | input | 1 | Low defers acquisition until it rises |
| cmp_i | input | 1 | Comparator: high when trial code is at or below the input |
| trial_code_o | output | 14 | Trial code to the external converter, zero when idle |
| busy_no | output | 1 | Low while a search runs |
| pass_o | output | 33 | Per-channel select: 1 passes the input through |
| rd_req_i | input | 1 | Readback request |
| rd_sel_i | input | 6 | Readback register index |
| rd_valid_o | output | 1 | Readback data valid for one cycle |
| rd_data_o | output | 14 | Readback code |

## Verification
The bench builds the block with STEP_CLKS=3 and CAL_STEP_CLKS=7. With these values a single search and a calibrate search last 42 and 98 cycles, so the two durations are clearly different. Each search is also long enough that commands and readbacks can be placed in the middle of it, which exercises the ignore path and the held-readback path. The comparator is modelled as a compare of the trial code against a bench-held level. This lets the level change while a channel waits on track, and it lets the bench drive both extreme codes.

// File: rtl/acq_pkg.sv
package acq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } acq_st_e;
endpackage

// File: rtl/acq_cmd_if.sv
module acq_cmd_if #(
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              wr_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              offs_sel_i,
  input  logic              cal_i,
  output logic              cmd_vld_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic              cmd_offs_o,
  output logic              cmd_cal_o
);
  logic wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_q <= 1'b1;
    else         wr_q <= wr_ni;
  end

  // strobe release seen while selected
  assign cmd_vld_o  = wr_ni && !wr_q && !cs_ni;
  assign cmd_addr_o = addr_i;
  assign cmd_offs_o = offs_sel_i;
  assign cmd_cal_o  = cal_i;
endmodule

// File: rtl/acq_sar.sv
module acq_sar #(
  parameter int CODE_W        = 14,
  parameter int STEP_CLKS     = 2,
  parameter int CAL_STEP_CLKS = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              long_i,
  input  logic              cmp_i,
  output logic              run_o,
  output logic              done_o,
  output logic [CODE_W-1:0] result_o,
  output logic [CODE_W-1:0] trial_code_o
);
  localparam int MAX_STEP = (CAL_STEP_CLKS > STEP_CLKS) ? CAL_STEP_CLKS : STEP_CLKS;
  localparam int CNT_W    = $clog2(MAX_STEP + 1);
  localparam int BIT_W    = $clog2(CODE_W);

  logic              run_q, long_q;
  logic [BIT_W-1:0]  bit_q;
  logic [CNT_W-1:0]  cnt_q, limit;
  logic [CODE_W-1:0] acc_q, trial, acc_upd;
  logic              last_cnt;

  assign limit    = long_q ? CNT_W'(CAL_STEP_CLKS - 1) : CNT_W'(STEP_CLKS - 1);
  assign last_cnt = (cnt_q == limit);
  assign trial    = acc_q | ({{(CODE_W-1){1'b0}}, 1'b1} << bit_q);
  assign acc_upd  = cmp_i ? trial : acc_q;

  assign run_o        = run_q;
  assign done_o       = run_q && last_cnt && (bit_q == '0);
  assign result_o     = acc_upd;
  assign trial_code_o = run_q ? trial : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      long_q <= 1'b0;
      bit_q  <= '0;
      cnt_q  <= '0;
      acc_q  <= '0;
    end else if (start_i && !run_q) begin
      run_q  <= 1'b1;
      long_q <= long_i;
      bit_q  <= BIT_W'(CODE_W - 1);
      cnt_q  <= '0;
      acc_q  <= '0;
    end else if (run_q) begin
      if (last_cnt) begin
        acc_q <= acc_upd;
        cnt_q <= '0;
        if (bit_q == '0) run_q <= 1'b0;
        else             bit_q <= bit_q - 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  a_r5_msb_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !run_q) |=> (trial_code_o == {1'b1, {(CODE_W-1){1'b0}}}));
  a_r3_done_ends_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !run_o);
endmodule

// File: rtl/acq_bank.sv
module acq_bank #(
  parameter int N_CH   = 32,
  parameter int CODE_W = 14,
  parameter int N_REG  = N_CH + 1,
  parameter int SEL_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              we_all_i,
  input  logic [SEL_W-1:0]  we_sel_i,
  input  logic [CODE_W-1:0] wdata_i,
  input  logic              hold_i,
  input  logic              rd_req_i,
  input  logic [SEL_W-1:0]  rd_sel_i,
  output logic              rd_valid_o,
  output logic [CODE_W-1:0] rd_data_o
);
  logic [CODE_W-1:0] regs_q [N_REG];
  logic [N_REG-1:0]  hit_w;

  for (genvar i = 0; i < N_REG; i++) begin : g_reg
    assign hit_w[i] = we_i && (we_all_i ? (i < N_CH) : (we_sel_i == SEL_W'(i)));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       regs_q[i] <= '0;
      else if (hit_w[i]) regs_q[i] <= wdata_i;
    end

    a_r9_hold_untouched: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !hit_w[i] |=> $stable(regs_q[i]));
  end

  logic             pend_q, rd_valid_q;
  logic [SEL_W-1:0] pend_sel_q, sel_eff;
  logic [CODE_W-1:0] rd_data_q;

  assign sel_eff = pend_q ? pend_sel_q : rd_sel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      pend_sel_q <= '0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= !hold_i && (pend_q || rd_req_i);
      if (!hold_i && (pend_q || rd_req_i))
        rd_data_q <= (sel_eff < SEL_W'(N_REG)) ? regs_q[sel_eff] : '0;
      if (hold_i && rd_req_i) begin
        pend_q     <= 1'b1;
        pend_sel_q <= rd_sel_i;
      end else if (!hold_i) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = rd_data_q;

  a_r12_read_deferred: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && hold_i) |=> !rd_valid_o);
endmodule

// File: rtl/acq_seq.sv
module acq_seq
  import acq_pkg::*;
#(
  parameter int N_CH          = 32,
  parameter int CODE_W        = 14,
  parameter int STEP_CLKS     = 2,
  parameter int CAL_STEP_CLKS = 6,
  localparam int ADDR_W       = $clog2(N_CH),
  localparam int N_REG        = N_CH + 1,
  localparam int SEL_W        = $clog2(N_REG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              wr_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              offs_sel_i,
  input  logic              cal_i,
  input  logic              track_i,
  input  logic              cmp_i,
  output logic [CODE_W-1:0] trial_code_o,
  output logic              busy_no,
  output logic [N_REG-1:0]  pass_o,
  input  logic              rd_req_i,
  input  logic [SEL_W-1:0]  rd_sel_i,
  output logic              rd_valid_o,
  output logic [CODE_W-1:0] rd_data_o
);
  logic              cmd_vld, cmd_offs, cmd_cal;
  logic [ADDR_W-1:0] cmd_addr;
  logic [SEL_W-1:0]  cmd_sel;

  acq_cmd_if #(.ADDR_W(ADDR_W)) u_cmd (
    .clk_i, .rst_ni, .cs_ni, .wr_ni, .addr_i, .offs_sel_i, .cal_i,
    .cmd_vld_o(cmd_vld), .cmd_addr_o(cmd_addr),
    .cmd_offs_o(cmd_offs), .cmd_cal_o(cmd_cal)
  );

  acq_st_e          st_q;
  logic [SEL_W-1:0] tgt_sel_q;
  logic             tgt_cal_q, track_q;
  logic             accept, start, sar_run, sar_done;
  logic [CODE_W-1:0] sar_result;

  assign cmd_sel = cmd_offs ? SEL_W'(N_CH) : SEL_W'(cmd_addr);
  assign accept  = cmd_vld && (st_q != ST_RUN);
  assign start   = (accept && track_i) ||
                   (!accept && st_q == ST_WAIT && track_i && !track_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      tgt_sel_q <= '0;
      tgt_cal_q <= 1'b0;
      track_q   <= 1'b0;
    end else begin
      track_q <= track_i;
      if (accept) begin
        tgt_sel_q <= cmd_sel;
        tgt_cal_q <= cmd_cal;
      end
      if (sar_done)    st_q <= ST_IDLE;
      else if (start)  st_q <= ST_RUN;
      else if (accept) st_q <= ST_WAIT;
    end
  end

  acq_sar #(
    .CODE_W(CODE_W), .STEP_CLKS(STEP_CLKS), .CAL_STEP_CLKS(CAL_STEP_CLKS)
  ) u_sar (
    .clk_i, .rst_ni,
    .start_i(start), .long_i(accept ? cmd_cal : tgt_cal_q), .cmp_i,
    .run_o(sar_run), .done_o(sar_done), .result_o(sar_result),
    .trial_code_o
  );

  acq_bank #(
    .N_CH(N_CH), .CODE_W(CODE_W), .N_REG(N_REG), .SEL_W(SEL_W)
  ) u_bank (
    .clk_i, .rst_ni,
    .we_i(sar_done), .we_all_i(tgt_cal_q), .we_sel_i(tgt_sel_q), .wdata_i(sar_result),
    .hold_i(sar_run), .rd_req_i, .rd_sel_i, .rd_valid_o, .rd_data_o
  );

  assign busy_no = !sar_run;

  for (genvar i = 0; i < N_REG; i++) begin : g_pass
    assign pass_o[i] = (st_q != ST_IDLE) &&
                       (tgt_cal_q ? (i < N_CH) : (tgt_sel_q == SEL_W'(i)));
  end

  a_r3_start_now: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && track_i) |=> !busy_no);
  a_r4_defer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !track_i) |=> (busy_no && (pass_o != '0)));
  a_r6_pass_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_no |-> (pass_o != '0));
  a_r8_cal_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_no && tgt_cal_q) |-> ((&pass_o[N_CH-1:0]) && !pass_o[N_CH]));
  a_r10_ignore_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_no && cmd_vld) |=> ($stable(tgt_sel_q) && $stable(tgt_cal_q)));
endmodule

// File: tb/acq_seq_tb.sv
`timescale 1ns/1ps
module acq_seq_tb;
  localparam int N_CH = 32, CODE_W = 14, STEP = 3, CAL = 7, N_REG = 33;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, cs_n, wr_n, offs, cal, track, cmp, rd_req, busy_n, rd_valid;
  logic [4:0]  addr;
  logic [5:0]  rd_sel;
  logic [13:0] trial, rd_data, vin;
  logic [32:0] pass, ep;

  assign cmp = (trial <= vin);

  acq_seq #(.N_CH(N_CH), .CODE_W(CODE_W), .STEP_CLKS(STEP), .CAL_STEP_CLKS(CAL)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .wr_ni(wr_n), .addr_i(addr),
    .offs_sel_i(offs), .cal_i(cal), .track_i(track), .cmp_i(cmp),
    .trial_code_o(trial), .busy_no(busy_n), .pass_o(pass),
    .rd_req_i(rd_req), .rd_sel_i(rd_sel), .rd_valid_o(rd_valid), .rd_data_o(rd_data)
  );

  int n_chk = 0, n_fail = 0;

  task automatic check(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_st, m_cnt, m_tgt, m_rdv, m_rdd, m_rdp, m_rds, s, nt;
  int m_regs[N_REG];
  bit m_wr_prev, m_trk_prev, acc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_tgt = 0; m_rdv = 0; m_rdd = 0; m_rdp = 0; m_rds = 0;
      for (int i = 0; i < N_REG; i++) m_regs[i] = 0;
      m_wr_prev = 1; m_trk_prev = 0;
    end else begin
      if (m_st != 2 && (m_rdp != 0 || rd_req)) begin
        s = (m_rdp != 0) ? m_rds : int'(rd_sel);
        m_rdd = (s < N_REG) ? m_regs[s] : 0;
        m_rdv = 1; m_rdp = 0;
      end else begin
        m_rdv = 0;
        if (m_st == 2 && rd_req) begin m_rdp = 1; m_rds = int'(rd_sel); end
      end
      acc = wr_n && !m_wr_prev && !cs_n && m_st != 2;
      nt  = cal ? 33 : (offs ? 32 : int'(addr));
      if (m_st == 2) begin
        m_cnt--;
        if (m_cnt == 0) begin
          if (m_tgt == 33) for (int i = 0; i < N_CH; i++) m_regs[i] = int'(vin);
          else m_regs[m_tgt] = int'(vin);
          m_st = 0;
        end
      end else if (acc) begin
        m_tgt = nt;
        if (track) begin m_st = 2; m_cnt = 14 * ((nt == 33) ? CAL : STEP); end
        else m_st = 1;
      end else if (m_st == 1 && track && !m_trk_prev) begin
        m_st = 2; m_cnt = 14 * ((m_tgt == 33) ? CAL : STEP);
      end
      m_wr_prev = wr_n; m_trk_prev = track;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < N_REG; i++)
        ep[i] = (m_st != 0) && ((m_tgt == 33) ? (i < N_CH) : (i == m_tgt));
      check("R3 busy_no vs model", busy_n, (m_st != 2));
      check("R6 pass_o vs model", pass, ep);
      check("R11 rd_valid vs model", rd_valid, m_rdv);
      if (m_rdv != 0) check("R11 rd_data vs model", rd_data, m_rdd);
      if (m_st != 2) check("R5 trial idle zero", trial, 0);
    end
  end

  task automatic cmd(input int a, input bit o, input bit c, input bit sel = 1);
    @(negedge clk); cs_n = !sel; wr_n = 0; addr = a[4:0]; offs = o; cal = c;
    @(negedge clk); wr_n = 1;
    @(negedge clk); cs_n = 1; offs = 0; cal = 0;
  endtask

  task automatic wait_done();
    int k = 0;
    while (!busy_n && k < 5000) begin @(negedge clk); k++; end
    @(negedge clk);
  endtask

  task automatic busy_len(input string tag, input int exp);
    int n = 0;
    while (!busy_n && n < 5000) begin n++; @(negedge clk); end
    check(tag, n, exp);
  endtask

  task automatic rd(input int sel, input int exp, input string tag);
    int k = 0;
    @(negedge clk); rd_req = 1; rd_sel = sel[5:0];
    @(negedge clk); rd_req = 0;
    while (!rd_valid && k < 5000) begin @(negedge clk); k++; end
    check(tag, rd_data, exp);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 0; cs_n = 1; wr_n = 1; addr = 0; offs = 0; cal = 0; track = 1;
    rd_req = 0; rd_sel = 0; vin = 0;
    repeat (3) @(negedge clk);
    check("R1 busy high in reset", busy_n, 1);
    check("R1 pass clear in reset", pass, 0);
    check("R1 trial zero in reset", trial, 0);
    rst_n = 1;
    rd(0, 0, "R1 ch0 zero");
    rd(32, 0, "R1 offset zero");

    // R3/R5/R6 single channel, track high
    vin = 14'h1234;
    cmd(5, 0, 0);
    check("R3 busy low at once", busy_n, 0);
    check("R5 first trial is msb", trial, 14'h2000);
    check("R6 pass on target", pass[5], 1);
    busy_len("R3 busy duration", 14 * STEP);
    check("R6 pass drops with busy", pass, 0);
    rd(5, 14'h1234, "R5 stored code");
    rd(4, 0, "R9 neighbour kept");

    // R7 offset select ignores address
    vin = 14'h3FFF;
    cmd(7, 1, 0);
    check("R7 pass on offset", pass[32], 1);
    wait_done();
    rd(32, 14'h3FFF, "R7 offset stored full scale");
    rd(7, 0, "R7 addressed channel untouched");

    // R4 deferred by track
    @(negedge clk); track = 0; vin = 14'h0AAA;
    cmd(9, 0, 0);
    repeat (4) @(negedge clk);
    check("R4 busy stays high", busy_n, 1);
    check("R4 pass through while waiting", pass[9], 1);
    vin = 14'h0555;
    @(negedge clk); track = 1;
    @(negedge clk);
    check("R4 start after track rise", busy_n, 0);
    wait_done();
    rd(9, 14'h0555, "R4 level at rise stored");

    // R2 chip select high
    cmd(4, 0, 0, 0);
    repeat (3) @(negedge clk);
    check("R2 no start without select", busy_n, 1);
    check("R2 no pass without select", pass, 0);

    // R10 command during busy
    vin = 14'h0101;
    cmd(1, 0, 0);
    cmd(2, 0, 0);
    wait_done();
    repeat (3) @(negedge clk);
    check("R10 no second search", busy_n, 1);
    rd(2, 0, "R10 ignored channel");
    rd(1, 14'h0101, "R10 first channel stored");

    // R12 readback during busy
    vin = 14'h0777;
    cmd(3, 0, 0);
    @(negedge clk); rd_req = 1; rd_sel = 6'd3;
    @(negedge clk); rd_req = 0;
    while (!busy_n) begin
      check("R12 no early readback", rd_valid, 0);
      @(negedge clk);
    end
    begin
      int k = 0;
      while (!rd_valid && k < 100) begin @(negedge clk); k++; end
      check("R12 held readback new code", rd_data, 14'h0777);
      check("R12 served one cycle after busy", k, 1);
    end

    // R8 calibrate
    vin = 14'h2468;
    cmd(0, 0, 1);
    check("R8 all regular pass", pass, {1'b0, {32{1'b1}}});
    busy_len("R8 calibrate duration", 14 * CAL);
    rd(0, 14'h2468, "R8 ch0 loaded");
    rd(31, 14'h2468, "R8 ch31 loaded");
    rd(32, 14'h3FFF, "R8 offset kept");

    // R5 zero code
    vin = 14'h0000;
    cmd(5, 0, 0);
    wait_done();
    rd(5, 0, "R5 zero code");
    rd(9, 14'h2468, "R9 persistence");
    rd(40, 0, "R11 out of range index");

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule